// File: doc/BRIEF.md
# Dual Seven-Segment Latch Writer

This block feeds two seven-segment digits that sit on one shared 7-bit segment bus. Each digit has its own external transparent latch with an active-high enable. The block takes two segment patterns, one per digit. In these patterns a 1 means the segment should light. The block writes the patterns into the two latches in turn, one digit per clock cycle. To write a digit, it drives the bus with that digit's pattern and raises that digit's enable for exactly one cycle. Each latch therefore receives fresh data every second cycle, which is half the clock rate.

The digits are common anode, so the bus is active low: a lit segment is a 0 on its bus bit and a dark segment is a 1. The bus value and the enable come from the same register stage. The bus is therefore steady for the whole cycle in which an enable is high. A pattern is sampled on the clock edge that opens its digit's slot. A change to that pattern later in the slot does not reach the latch until the digit's next slot.

Top module: `dual_digit_latch_drv`

## Requirements
- R1: After any clock edge at which the synchronous active-high reset is sampled high, both enables are low and every bus bit is 1 (all segments dark).
- R2: The first clock edge after reset is released opens the left digit's slot, so enLeft is high in the cycle that follows that edge.
- R3: enLeft and enRight are never high in the same cycle.
- R4: Outside reset, the enables alternate every cycle. Each enable is high for one cycle and then low for the next cycle, while the other enable is high.
- R5: While enLeft is high, segBus equals the bitwise inverse of patLeft as sampled at the edge that raised enLeft. Bus bit i carries segment i, with bit 0 for segment A through bit 6 for segment G.
- R6: While enRight is high, segBus equals the bitwise inverse of patRight as sampled at the edge that raised enRight, with the same bit order as R5.
- R7: A pattern change made partway through a slot does not alter the bus or the value written to either latch during that slot. The new value appears in that digit's next slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one digit is written per cycle |
| rst | input | 1 | Synchronous reset, active high |
| patLeft | input | 7 | Left digit pattern, 1 = segment lit, bit 0 = A .. bit 6 = G |
| patRight | input | 7 | Right digit pattern, same encoding as patLeft |
| segBus | output | 7 | Shared segment bus, active low |
| enLeft | output | 1 | Left latch enable, one-cycle high pulse |
| enRight | output | 1 | Right latch enable, one-cycle high pulse |

## Verification
The only internal state is the slot phase, and an error in it shows on the enables within one cycle. A stuck phase stops the alternation, and a phase that comes out of reset on the wrong digit raises enRight first. A wrong pattern select or a missing inversion shows on segBus in the same cycle its enable is high. The bench's latch models then hold that wrong value until the next slot of that digit, two cycles later.

// File: rtl/dlatch_pkg.sv
package dlatch_pkg;
  typedef struct packed {
    logic driveLeft;
    logic driveRight;
  } slotStrobe_t;
endpackage

// File: rtl/dlatch_ctrl.sv
module dlatch_ctrl
  import dlatch_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output slotStrobe_t strobe
);
  // phase 0 selects the left slot at the coming edge, phase 1 the right
  logic phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  always_comb begin
    strobe.driveLeft  = ~rst & ~phase;
    strobe.driveRight = ~rst &  phase;
  end
endmodule

// File: rtl/dlatch_datapath.sv
module dlatch_datapath
  import dlatch_pkg::*;
#(
  parameter int SEG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  slotStrobe_t      strobe,
  input  logic [SEG_W-1:0] patLeft,
  input  logic [SEG_W-1:0] patRight,
  output logic [SEG_W-1:0] segBus,
  output logic             enLeft,
  output logic             enRight
);
  localparam logic [SEG_W-1:0] ALL_DARK = {SEG_W{1'b1}};

  // bus and enables share one register stage, so data is steady while enabled
  always_ff @(posedge clk) begin
    if (rst) begin
      segBus  <= ALL_DARK;
      enLeft  <= 1'b0;
      enRight <= 1'b0;
    end else begin
      enLeft  <= strobe.driveLeft;
      enRight <= strobe.driveRight;
      if (strobe.driveLeft)       segBus <= ~patLeft;
      else if (strobe.driveRight) segBus <= ~patRight;
      else                        segBus <= ALL_DARK;
    end
  end

  p_reset_blank_r1: assert property (@(posedge clk)
    rst |=> (segBus == ALL_DARK && !enLeft && !enRight));

  p_first_left_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |=> (enLeft && !enRight));

  p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(enLeft && enRight));

  p_alt_left_r4: assert property (@(posedge clk) disable iff (rst)
    enLeft |=> (enRight && !enLeft));

  p_alt_right_r4: assert property (@(posedge clk) disable iff (rst)
    enRight |=> (enLeft && !enRight));

  p_left_data_r5: assert property (@(posedge clk) disable iff (rst)
    enLeft |-> (segBus == ~$past(patLeft)));

  p_right_data_r6: assert property (@(posedge clk) disable iff (rst)
    enRight |-> (segBus == ~$past(patRight)));
endmodule

// File: rtl/dual_digit_latch_drv.sv
module dual_digit_latch_drv
  import dlatch_pkg::*;
#(
  parameter int SEG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEG_W-1:0] patLeft,
  input  logic [SEG_W-1:0] patRight,
  output logic [SEG_W-1:0] segBus,
  output logic             enLeft,
  output logic             enRight
);
  slotStrobe_t strobe;

  dlatch_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  dlatch_datapath #(.SEG_W(SEG_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .patLeft  (patLeft),
    .patRight (patRight),
    .segBus   (segBus),
    .enLeft   (enLeft),
    .enRight  (enRight)
  );
endmodule

// File: tb/dual_digit_latch_drv_test.sv
module dual_digit_latch_drv_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // each entry: {left pattern, right pattern}, 1 = segment lit
  localparam logic [13:0] VEC [NVEC] = '{
    {7'h00, 7'h00}, {7'h7F, 7'h00}, {7'h00, 7'h7F}, {7'h3F, 7'h06},
    {7'h5B, 7'h4F}, {7'h01, 7'h40}, {7'h55, 7'h2A}, {7'h7F, 7'h7F}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] patLeft = 7'h00;
  logic [6:0] patRight = 7'h00;
  logic [6:0] segBus;
  logic enLeft, enRight;
  logic [6:0] latchL = 7'h7F;
  logic [6:0] latchR = 7'h7F;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_digit_latch_drv uut (
    .clk(clk), .rst(rst), .patLeft(patLeft), .patRight(patRight),
    .segBus(segBus), .enLeft(enLeft), .enRight(enRight)
  );

  // transparent latch models: value seen mid-cycle while enable is high
  always @(negedge clk) begin
    if (enLeft)  latchL <= segBus;
    if (enRight) latchR <= segBus;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(segBus == 7'h7F, "R1 bus blank", segBus, 7'h7F);
    check(!enLeft && !enRight, "R1 enables low", {enLeft, enRight}, 0);

    // vector walk
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      patLeft  = VEC[i][13:7];
      patRight = VEC[i][6:0];
      @(negedge clk);
      if (i == 0) check(enLeft && !enRight, "R2 left first", {enLeft, enRight}, 2);
      check(enLeft && !enRight, "R4 left slot", {enLeft, enRight}, 2);
      check(segBus == ~VEC[i][13:7], "R5 left bus", segBus, ~VEC[i][13:7]);
      @(negedge clk);
      check(enRight && !enLeft, "R3 R4 right slot", {enLeft, enRight}, 1);
      check(segBus == ~VEC[i][6:0], "R6 right bus", segBus, ~VEC[i][6:0]);
      @(posedge clk); #1;
      check(latchL == ~VEC[i][13:7], "R5 left latch", latchL, ~VEC[i][13:7]);
      check(latchR == ~VEC[i][6:0], "R6 right latch", latchR, ~VEC[i][6:0]);
      @(negedge clk);
      // undo the extra half-cycle: we are now in the next left slot
      check(enLeft && !enRight, "R4 wrap to left", {enLeft, enRight}, 2);
      @(negedge clk);
    end

    // R7: mid-slot changes; now at negedge inside a right slot, next edge is left
    patLeft = 7'h12; patRight = 7'h34;
    @(negedge clk);
    check(segBus == ~7'h12, "R7 left sampled", segBus, ~7'h12);
    patLeft = 7'h6D;               // mid left slot
    @(negedge clk);
    check(latchL == ~7'h12, "R7 left latch holds", latchL, ~7'h12);
    check(segBus == ~7'h34, "R7 right bus", segBus, ~7'h34);
    patRight = 7'h21;              // mid right slot
    @(negedge clk);
    check(segBus == ~7'h6D, "R7 left new value", segBus, ~7'h6D);
    check(latchR == ~7'h34, "R7 right latch holds", latchR, ~7'h34);
    @(negedge clk);
    check(segBus == ~7'h21, "R7 right new value", segBus, ~7'h21);

    // reset mid-run, then restart on left (R1, R2)
    rst = 1'b1;
    @(negedge clk);
    check(segBus == 7'h7F && !enLeft && !enRight, "R1 mid-run reset", {enLeft, enRight, segBus}, 7'h7F);
    patLeft = 7'h08; patRight = 7'h70;
    rst = 1'b0;
    @(negedge clk);
    check(enLeft && !enRight, "R2 restart left", {enLeft, enRight}, 2);
    check(segBus == ~7'h08, "R5 restart left bus", segBus, ~7'h08);
    @(negedge clk);
    check(enRight && !enLeft, "R3 restart right", {enLeft, enRight}, 1);
    check(segBus == ~7'h70, "R6 restart right bus", segBus, ~7'h70);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule